// File: doc/BRIEF.md
# ALU Status Flag Register

This block is the eight-bit processor status register that sits beside an eight-bit ALU. Each cycle the ALU may present an operation through a valid strobe, an operation class code, both operands and the result it produced. The register then derives and stores the half-carry, two's-complement overflow, negative, zero and carry flags, plus a sign flag. The sign flag gives the true sign of the result even when the arithmetic overflowed.

The two top bits are not arithmetic flags. The global interrupt enable is cleared by hardware when an interrupt is taken and set again by a return-from-interrupt. The bit-copy latch is written by a bit-store strobe and read through a dedicated output by bit-load instructions.

Saving and restoring the register around interrupt handlers is left to software. The ALU datapath itself lives outside this block.

Top module: `status_flag_reg`

## Requirements
- R1: A synchronous active-high reset clears all eight register bits to 0x00, so interrupts start disabled.
- R2: The status output packs, from bit 7 down to bit 0: interrupt enable, bit-copy latch, half carry, sign, overflow, negative, zero, carry. The `t_bit` output always equals bit 6.
- R3: On the clock edge after `op_valid` is high with class add (2'b00), subtract (2'b01) or logic (2'b10), the negative flag equals the result MSB. The zero flag is 1 exactly when the result is all zeros.
- R4: The sign flag always equals negative XOR overflow.
- R5: For an add with result = a + b: carry is the carry out of bit 7, half carry is the carry out of bit 3, and overflow is set when both operands share a sign that differs from the result's sign.
- R6: For a subtract with result = a - b: carry is set when a < b unsigned, half carry is set when a[3:0] < b[3:0], and overflow is set when the operand signs differ and the result sign differs from a's sign.
- R7: A logic-class operation clears overflow and leaves carry and half carry at their previous values.
- R8: When `op_valid` is low, or the class is 2'b11 (no update), bits 5 to 0 keep their values.
- R9: `irq_take` clears the interrupt-enable bit on the next edge, even if `irq_return` is high in the same cycle.
- R10: `irq_return` alone sets the interrupt-enable bit on the next edge. With neither strobe, the bit holds.
- R11: `bit_store` loads `bit_src` into the bit-copy latch on the next edge. Otherwise the latch holds.
- R12: ALU operations never change bits 7 and 6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | An ALU operation completes this cycle |
| op_class | input | 2 | 00 add, 01 subtract, 10 logic, 11 no update |
| opnd_a | input | 8 | First operand (minuend for subtract) |
| opnd_b | input | 8 | Second operand (subtrahend for subtract) |
| result | input | 8 | Result produced by the ALU |
| irq_take | input | 1 | Interrupt is being entered |
| irq_return | input | 1 | Return-from-interrupt executes |
| bit_store | input | 1 | Bit-store strobe |
| bit_src | input | 1 | Register bit chosen by the bit-store |
| status | output | 8 | Full status register |
| t_bit | output | 1 | Bit-copy latch, for bit-load |

## Verification
Every state bit is visible on `status` one edge after the stimulus that changes it. A wrong carry chain, a misrouted priority or a stale hold therefore shows at the next sampling point, with no latency to hide it. The error can only stay masked if a later update overwrites the wrong bit before it is read.

The risky cases are a held carry that a logic operation wrongly overwrites, and a sign bit that disagrees with negative and overflow after an overflowing add. Interrupt strobes that collide in one cycle are also covered. Each of these is driven directly as well as through a long random mix of operations.

// File: rtl/sfr_pkg.sv
package sfr_pkg;

    // ALU operation classes as presented on op_class
    typedef enum logic [1:0] {
        OPC_ADD   = 2'b00,
        OPC_SUB   = 2'b01,
        OPC_LOGIC = 2'b10,
        OPC_NONE  = 2'b11
    } op_class_e;

    // Full register image, MSB first: this packing is the output layout
    typedef struct packed {
        logic ie;   // global interrupt enable
        logic tb;   // bit-copy latch
        logic hc;   // half carry
        logic sg;   // sign
        logic ov;   // two's complement overflow
        logic ng;   // negative
        logic zr;   // zero
        logic cy;   // carry / borrow
    } status_t;

    // Fields derived from an ALU operation (sign is formed from these)
    typedef struct packed {
        logic hc;
        logic ov;
        logic ng;
        logic zr;
        logic cy;
    } arith_t;

    // Fields owned by control events
    typedef struct packed {
        logic ie;
        logic tb;
    } ctrl_t;

    localparam int STATUS_W = $bits(status_t);

    function automatic logic maj3(input logic x, input logic y, input logic z);
        return (x & y) | (y & z) | (z & x);
    endfunction

endpackage

// File: rtl/sfr_flag_calc.sv
module sfr_flag_calc
    import sfr_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int HALF_W = 4
) (
    input  logic              op_valid,
    input  op_class_e         op_class,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic [DATA_W-1:0] result,
    input  arith_t            prev,
    output arith_t            next
);

    localparam int MSB = DATA_W - 1;

    // Carry chain for add, borrow chain for subtract, one cell per bit
    logic [DATA_W:0] add_cy;
    logic [DATA_W:0] sub_bw;

    assign add_cy[0] = 1'b0;
    assign sub_bw[0] = 1'b0;

    for (genvar k = 0; k < DATA_W; k++) begin : g_cell
        assign add_cy[k+1] = maj3(opnd_a[k], opnd_b[k], add_cy[k]);
        assign sub_bw[k+1] = maj3(~opnd_a[k], opnd_b[k], sub_bw[k]);
    end

    logic res_zero;
    logic res_neg;

    assign res_zero = ~|result;
    assign res_neg  = result[MSB];

    always_comb begin
        next = prev;
        if (op_valid) begin
            unique case (op_class)
                OPC_ADD: begin
                    next.cy = add_cy[DATA_W];
                    next.hc = add_cy[HALF_W];
                    next.ov = add_cy[DATA_W] ^ add_cy[MSB];
                    next.ng = res_neg;
                    next.zr = res_zero;
                end
                OPC_SUB: begin
                    next.cy = sub_bw[DATA_W];
                    next.hc = sub_bw[HALF_W];
                    next.ov = sub_bw[DATA_W] ^ sub_bw[MSB];
                    next.ng = res_neg;
                    next.zr = res_zero;
                end
                OPC_LOGIC: begin
                    next.ov = 1'b0;
                    next.ng = res_neg;
                    next.zr = res_zero;
                end
                default: begin
                    next = prev;
                end
            endcase
        end
    end

endmodule

// File: rtl/sfr_ctrl_bits.sv
module sfr_ctrl_bits
    import sfr_pkg::*;
(
    input  logic  irq_take,
    input  logic  irq_return,
    input  logic  bit_store,
    input  logic  bit_src,
    input  ctrl_t prev,
    output ctrl_t next
);

    always_comb begin
        next = prev;
        // Entry has priority over return
        if (irq_take) begin
            next.ie = 1'b0;
        end else if (irq_return) begin
            next.ie = 1'b1;
        end
        if (bit_store) begin
            next.tb = bit_src;
        end
    end

endmodule

// File: rtl/status_flag_reg.sv
module status_flag_reg
    import sfr_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int HALF_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    input  logic [1:0]        op_class,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic [DATA_W-1:0] result,
    input  logic              irq_take,
    input  logic              irq_return,
    input  logic              bit_store,
    input  logic              bit_src,
    output logic [STATUS_W-1:0] status,
    output logic              t_bit
);

    status_t   sreg_q;
    status_t   sreg_d;
    arith_t    ar_cur;
    arith_t    ar_nxt;
    ctrl_t     ct_cur;
    ctrl_t     ct_nxt;
    op_class_e cls;

    assign cls = op_class_e'(op_class);

    assign ar_cur = '{hc: sreg_q.hc, ov: sreg_q.ov, ng: sreg_q.ng,
                      zr: sreg_q.zr, cy: sreg_q.cy};
    assign ct_cur = '{ie: sreg_q.ie, tb: sreg_q.tb};

    sfr_flag_calc #(
        .DATA_W (DATA_W),
        .HALF_W (HALF_W)
    ) u_calc (
        .op_valid (op_valid),
        .op_class (cls),
        .opnd_a   (opnd_a),
        .opnd_b   (opnd_b),
        .result   (result),
        .prev     (ar_cur),
        .next     (ar_nxt)
    );

    sfr_ctrl_bits u_ctrl (
        .irq_take   (irq_take),
        .irq_return (irq_return),
        .bit_store  (bit_store),
        .bit_src    (bit_src),
        .prev       (ct_cur),
        .next       (ct_nxt)
    );

    always_comb begin
        sreg_d.ie = ct_nxt.ie;
        sreg_d.tb = ct_nxt.tb;
        sreg_d.hc = ar_nxt.hc;
        sreg_d.sg = ar_nxt.ng ^ ar_nxt.ov;
        sreg_d.ov = ar_nxt.ov;
        sreg_d.ng = ar_nxt.ng;
        sreg_d.zr = ar_nxt.zr;
        sreg_d.cy = ar_nxt.cy;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sreg_q <= '0;
        end else begin
            sreg_q <= sreg_d;
        end
    end

    assign status = sreg_q;
    assign t_bit  = sreg_q.tb;

endmodule

// File: rtl/status_flag_reg_chk.sv
module status_flag_reg_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              op_valid,
    input logic [1:0]        op_class,
    input logic [DATA_W-1:0] result,
    input logic              irq_take,
    input logic              irq_return,
    input logic              bit_store,
    input logic              bit_src,
    input logic [7:0]        status,
    input logic              t_bit
);

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> status == 8'h00);

    assert_t_output_R2: assert property (@(posedge clk) disable iff (rst)
        t_bit == status[6]);

    assert_nz_update_R3: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_class != 2'b11) |=>
            (status[2] == $past(result[DATA_W-1]) && status[1] == ($past(result) == '0)));

    assert_sign_rule_R4: assert property (@(posedge clk) disable iff (rst)
        status[4] == (status[2] ^ status[3]));

    assert_logic_flags_R7: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_class == 2'b10) |=>
            (status[3] == 1'b0 && status[0] == $past(status[0]) && status[5] == $past(status[5])));

    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (!op_valid || op_class == 2'b11) |=> $stable(status[5:0]));

    assert_irq_clear_R9: assert property (@(posedge clk) disable iff (rst)
        irq_take |=> status[7] == 1'b0);

    assert_irq_set_R10: assert property (@(posedge clk) disable iff (rst)
        (irq_return && !irq_take) |=> status[7] == 1'b1);

    assert_t_load_R11: assert property (@(posedge clk) disable iff (rst)
        bit_store |=> t_bit == $past(bit_src));

    assert_t_hold_R12: assert property (@(posedge clk) disable iff (rst)
        (!bit_store && !irq_take && !irq_return) |=> $stable(status[7:6]));

endmodule

bind status_flag_reg status_flag_reg_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .op_valid   (op_valid),
    .op_class   (op_class),
    .result     (result),
    .irq_take   (irq_take),
    .irq_return (irq_return),
    .bit_store  (bit_store),
    .bit_src    (bit_src),
    .status     (status),
    .t_bit      (t_bit)
);

// File: tb/status_flag_reg_bench.sv
module status_flag_reg_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       op_valid = 1'b0;
    logic [1:0] op_class = 2'b11;
    logic [7:0] opnd_a = '0;
    logic [7:0] opnd_b = '0;
    logic [7:0] result = '0;
    logic       irq_take = 1'b0;
    logic       irq_return = 1'b0;
    logic       bit_store = 1'b0;
    logic       bit_src = 1'b0;
    logic [7:0] status;
    logic       t_bit;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;
    logic [7:0] model = 8'h00;

    always #(CLK_PERIOD/2) clk = ~clk;

    status_flag_reg u_status_flag_reg (
        .clk        (clk),
        .rst        (rst),
        .op_valid   (op_valid),
        .op_class   (op_class),
        .opnd_a     (opnd_a),
        .opnd_b     (opnd_b),
        .result     (result),
        .irq_take   (irq_take),
        .irq_return (irq_return),
        .bit_store  (bit_store),
        .bit_src    (bit_src),
        .status     (status),
        .t_bit      (t_bit)
    );

    // Expected next register from the requirements
    function automatic logic [7:0] expect_next(
        input logic [7:0] cur, input logic v, input logic [1:0] cls,
        input logic [7:0] a, input logic [7:0] b, input logic [7:0] r,
        input logic tk, input logic rt, input logic bs, input logic src);
        logic ie, tb, hc, ov, ng, zr, cy;
        logic [8:0] wide;
        logic [4:0] low;
        ie = cur[7]; tb = cur[6]; hc = cur[5]; ov = cur[3];
        ng = cur[2]; zr = cur[1]; cy = cur[0];
        if (v && cls == 2'b00) begin                  // R5
            wide = {1'b0, a} + {1'b0, b};
            low  = {1'b0, a[3:0]} + {1'b0, b[3:0]};
            cy = wide[8];
            hc = low[4];
            ov = (a[7] == b[7]) && (r[7] != a[7]);
        end else if (v && cls == 2'b01) begin         // R6
            cy = a < b;
            hc = a[3:0] < b[3:0];
            ov = (a[7] != b[7]) && (r[7] != a[7]);
        end else if (v && cls == 2'b10) begin         // R7
            ov = 1'b0;
        end
        if (v && cls != 2'b11) begin                  // R3
            ng = r[7];
            zr = (r == 8'h00);
        end
        if (tk) ie = 1'b0;                            // R9
        else if (rt) ie = 1'b1;                       // R10
        if (bs) tb = src;                             // R11
        return {ie, tb, hc, ng ^ ov, ov, ng, zr, cy}; // R2, R4
    endfunction

    task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
        end
    endtask

    // Drive one cycle at the falling edge, sample at the next falling edge
    task automatic step(input string tag, input logic v, input logic [1:0] cls,
                        input logic [7:0] a, input logic [7:0] b, input logic [7:0] r,
                        input logic tk, input logic rt, input logic bs, input logic src);
        logic [7:0] exp;
        op_valid = v; op_class = cls; opnd_a = a; opnd_b = b; result = r;
        irq_take = tk; irq_return = rt; bit_store = bs; bit_src = src;
        exp = expect_next(model, v, cls, a, b, r, tk, rt, bs, src);
        @(negedge clk);
        check8(tag, status, exp);
        check8("R2 t_bit", {7'b0, t_bit}, {7'b0, exp[6]});
        model = exp;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = 32'h5A17;
        void'($urandom(seed));
        rst = 1'b1;
        repeat (3) @(negedge clk);
        // R1: reset value, taken while rst still high
        check8("R1 reset", status, 8'h00);
        rst = 1'b0;
        model = 8'h00;

        // R5: carry, overflow and zero from 0x80 + 0x80
        step("R5 add 80+80", 1, 2'b00, 8'h80, 8'h80, 8'h00, 0, 0, 0, 0);
        check8("R4 sign after overflow", {7'b0, status[4]}, 8'h01);
        // R5: half carry from 0x0F + 0x01
        step("R5 add 0F+01", 1, 2'b00, 8'h0F, 8'h01, 8'h10, 0, 0, 0, 0);
        check8("R5 half carry only", status, 8'h20);
        // R5/R4: positive overflow into negative
        step("R4 add 7F+01", 1, 2'b00, 8'h7F, 8'h01, 8'h80, 0, 0, 0, 0);
        check8("R4 V N S", status[5:0] & 6'h1C, 6'h0C);
        // R6: borrow on 0 - 1
        step("R6 sub 00-01", 1, 2'b01, 8'h00, 8'h01, 8'hFF, 0, 0, 0, 0);
        check8("R6 borrow flags", status, 8'h35);
        // R6: signed overflow 0x80 - 0x01
        step("R6 sub 80-01", 1, 2'b01, 8'h80, 8'h01, 8'h7F, 0, 0, 0, 0);
        // R6: equal operands, no borrow
        step("R6 sub 5A-5A", 1, 2'b01, 8'h5A, 8'h5A, 8'h00, 0, 0, 0, 0);
        // set carry, then R7 logic keeps it
        step("R6 sub 01-02", 1, 2'b01, 8'h01, 8'h02, 8'hFF, 0, 0, 0, 0);
        step("R7 logic zero", 1, 2'b10, 8'hF0, 8'h0F, 8'h00, 0, 0, 0, 0);
        check8("R7 carry held", {7'b0, status[0]}, 8'h01);
        // R8: no-update class and idle cycles
        step("R8 class none", 1, 2'b11, 8'hFF, 8'hFF, 8'h00, 0, 0, 0, 0);
        step("R8 valid low", 0, 2'b00, 8'h80, 8'h80, 8'h00, 0, 0, 0, 0);
        // R10 then R9 with collision
        step("R10 return", 0, 2'b11, 8'h00, 8'h00, 8'h00, 0, 1, 0, 0);
        check8("R10 ie set", {7'b0, status[7]}, 8'h01);
        step("R9 take and return", 0, 2'b11, 8'h00, 8'h00, 8'h00, 1, 1, 0, 0);
        check8("R9 ie clear", {7'b0, status[7]}, 8'h00);
        step("R10 return again", 0, 2'b11, 8'h00, 8'h00, 8'h00, 0, 1, 0, 0);
        step("R9 take alone", 0, 2'b11, 8'h00, 8'h00, 8'h00, 1, 0, 0, 0);
        // R11: bit store set and clear
        step("R11 store one", 0, 2'b11, 8'h00, 8'h00, 8'h00, 0, 0, 1, 1);
        check8("R11 t_bit one", {7'b0, t_bit}, 8'h01);
        // R12: ALU op with I and T set leaves them
        step("R12 set ie", 0, 2'b11, 8'h00, 8'h00, 8'h00, 0, 1, 0, 0);
        step("R12 alu keeps I T", 1, 2'b00, 8'hFF, 8'h01, 8'h00, 0, 0, 0, 0);
        check8("R12 top bits", {6'b0, status[7:6]}, 8'h03);
        step("R11 store zero", 0, 2'b11, 8'h00, 8'h00, 8'h00, 0, 0, 1, 0);

        // Random mix
        for (int i = 0; i < 600; i++) begin
            logic       v, tk, rt, bs, src;
            logic [1:0] cls;
            logic [7:0] a, b, r;
            string      tag;
            v   = ($urandom % 4) != 0;
            cls = 2'($urandom % 4);
            a   = 8'($urandom);
            b   = 8'($urandom);
            if ($urandom % 8 == 0) b = a;
            case (cls)
                2'b00: begin r = a + b; tag = "R5 random add"; end
                2'b01: begin r = a - b; tag = "R6 random sub"; end
                2'b10: begin
                    case ($urandom % 3)
                        0: r = a & b;
                        1: r = a | b;
                        default: r = a ^ b;
                    endcase
                    tag = "R7 random logic";
                end
                default: begin r = 8'($urandom); tag = "R8 random none"; end
            endcase
            if (!v) tag = "R8 random idle";
            tk  = ($urandom % 10) == 0;
            rt  = ($urandom % 7) == 0;
            bs  = ($urandom % 5) == 0;
            src = 1'($urandom);
            step(tag, v, cls, a, b, r, tk, rt, bs, src);
        end

        // R1: reset mid-run clears everything
        rst = 1'b1;
        @(negedge clk);
        check8("R1 reset again", status, 8'h00);
        rst = 1'b0;

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule